// File: doc/BRIEF.md
# SD Card Single-Block Data Phase Engine

This block carries out the data phase of one SD card block transfer over an SPI link, once the controlling logic has already issued a read-block or write-block command and the card has accepted it. It owns the SPI pins for the whole data phase. The number of payload bytes is a parameter. The default is 512 for a data block; a value of 16 lets the same engine fetch the 16-byte card-specific data register.

For a read, the engine polls the card with filler bytes until a start token arrives. It then presents each payload byte on a byte stream with a one-cycle valid strobe, and drops the two trailing check bytes. For a write, it sends a start token, then takes payload bytes from a ready/valid stream and sends two filler bytes where the check bytes would go. It then examines the card's acknowledge byte and waits while the card holds the line at zero.

Every transfer ends with chip select released and one more filler byte clocked, followed by a one-cycle completion pulse with an error flag. A small address helper converts a block number into the command argument for either card capacity class.

Top module: `sdx_block_engine`

## Requirements
- R1: After a synchronous active-low reset, spi_cs_n is 1, spi_sck is 0, spi_mosi is 1, and done, rd_valid, wr_ready, error and err_status are all 0.
- R2: In a read (write_mode=0 at start), the engine sends 0xFF bytes until it receives 0xFE. It then delivers exactly DATA_BYTES received bytes in order, each on rd_data with a one-cycle rd_valid pulse. Bytes are shifted MSB first in SPI mode 0: sck idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge.
- R3: After the read payload, the engine clocks two further bytes, sending 0xFF, and does not deliver them on rd_data.
- R4: If POLL_LIMIT consecutive received bytes are not 0xFE, the read ends with error=1 and no payload is delivered. A token received on poll number POLL_LIMIT still succeeds.
- R5: In a write, the engine sends 0xFE, then DATA_BYTES bytes taken from wr_data on cycles where wr_valid and wr_ready are both 1 (held-off producers are waited for), then two 0xFF bytes.
- R6: The byte received after the two 0xFF bytes is ANDed with 0x1F. A result of 0x05 means the card accepted the write. Any other result ends the transfer with error=1 and err_status set to received bits [3:1] (101 means check error, 110 means write error). err_status is 0 whenever error is 0.
- R7: After an accepted write, the engine keeps sending 0xFF while the card returns 0x00. It ends the transfer at the first non-zero byte, with error=0.
- R8: Every transfer ends with one final 0xFF byte clocked while spi_cs_n is 1; spi_cs_n is 0 for all earlier bytes. Then done pulses for one cycle, and error keeps the transfer outcome.
- R9: cmd_arg equals block_num*512 when high_cap=0 and block_num when high_cap=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a data phase (taken when idle) |
| write_mode | input | 1 | 1 = write block, 0 = read block; sampled with start |
| block_num | input | 32 | Block number to be converted into a command argument |
| high_cap | input | 1 | 1 = block-addressed card, 0 = byte-addressed card |
| cmd_arg | output | 32 | Command argument derived from block_num |
| rd_data | output | 8 | Received payload byte |
| rd_valid | output | 1 | One-cycle strobe qualifying rd_data |
| wr_data | input | 8 | Payload byte to send |
| wr_valid | input | 1 | wr_data holds a byte |
| wr_ready | output | 1 | Engine takes wr_data this cycle if wr_valid |
| done | output | 1 | One-cycle end-of-transfer pulse |
| error | output | 1 | Outcome of last transfer: 1 = failed |
| err_status | output | 3 | Status field of a rejected write acknowledge |
| spi_sck | output | 1 | SPI clock (mode 0) |
| spi_mosi | output | 1 | SPI data to card |
| spi_miso | input | 1 | SPI data from card |
| spi_cs_n | output | 1 | Card chip select, active low |

## Verification
The bench models the card as an SPI responder with a scripted reply per byte. It targets the limits of the token poll: a token on the very first byte, a token on the last permitted poll, and no token at all. An off-by-one counter would then fail a good read or hang past the limit. For writes, the acknowledge byte carries set high bits, which an engine without the 0x1F mask would reject. Two zero busy bytes follow, and an engine that did not wait would finish three bytes early. Both rejected status codes are checked on err_status. On every transfer the bench counts the bytes clocked and the chip select level on each one, which catches a missing tail byte, check bytes leaking onto rd_data, and write bytes repeated or lost under a stalling producer.

// File: rtl/sdx_pkg.sv
// Shared types and byte constants for the SD data-phase engine.
// Assumes SPI mode framing with 8-bit transfers.
package sdx_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RPOLL,
        ST_RDATA,
        ST_RCRC,
        ST_WTOK,
        ST_WDATA,
        ST_WCRC,
        ST_WRESP,
        ST_WBUSY,
        ST_TAIL
    } xfer_st_e;

    localparam logic [7:0] TOK_START = 8'hFE;
    localparam logic [7:0] FILL_BYTE = 8'hFF;
    localparam logic [7:0] ACK_MASK  = 8'h1F;
    localparam logic [7:0] ACK_OK    = 8'h05;
endpackage

// File: rtl/sdx_spi_byte.sv
// SPI mode-0 byte shifter: one 8-bit exchange per go pulse, MSB first.
// sck idles low; MISO sampled on the rising edge, MOSI changes on the falling edge.
// Assumes go is only raised while idle is 1; each sck half period lasts CLK_DIV clocks.
module sdx_spi_byte #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       fin,
    output logic [7:0] rx_byte,
    output logic       idle
);
    localparam int DIVW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIVW-1:0] DIV_LAST = DIVW'(CLK_DIV - 1);

    logic            act;
    logic            sck_r;
    logic [2:0]      bitc;
    logic [DIVW-1:0] divc;
    logic [7:0]      txsh;
    logic [7:0]      rxsh;

    // Shift engine: paces half periods, samples on rise, shifts on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= 1'b0;
            sck_r   <= 1'b0;
            bitc    <= '0;
            divc    <= '0;
            txsh    <= 8'hFF;
            rxsh    <= '0;
            rx_byte <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!act) begin
                if (go) begin
                    act   <= 1'b1;
                    txsh  <= tx_byte;
                    bitc  <= '0;
                    divc  <= '0;
                    sck_r <= 1'b0;
                end
            end else if (divc == DIV_LAST) begin
                divc <= '0;
                if (!sck_r) begin
                    sck_r <= 1'b1;
                    rxsh  <= {rxsh[6:0], miso};
                end else begin
                    sck_r <= 1'b0;
                    if (bitc == 3'd7) begin
                        act     <= 1'b0;
                        fin     <= 1'b1;
                        rx_byte <= rxsh;
                    end else begin
                        bitc <= bitc + 3'd1;
                        txsh <= {txsh[6:0], 1'b1};
                    end
                end
            end else begin
                divc <= divc + DIVW'(1);
            end
        end
    end

    // Pin drive: line held high between bytes.
    always_comb begin
        sck  = sck_r;
        mosi = act ? txsh[7] : 1'b1;
        idle = !act;
    end
endmodule

// File: rtl/sdx_addr_map.sv
// Converts a block number into the command argument for either capacity class.
// Byte-addressed cards take the block number scaled by the block size;
// block-addressed cards take it unchanged.
module sdx_addr_map #(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 9
) (
    input  logic [ADDR_W-1:0] block_num,
    input  logic              high_cap,
    output logic [ADDR_W-1:0] cmd_arg
);
    // Argument select: scale only for byte-addressed cards.
    always_comb begin
        cmd_arg = high_cap ? block_num : (block_num << BLK_SHIFT);
    end
endmodule

// File: rtl/sdx_ctrl.sv
// Sequencer for one data phase: token poll, payload, check bytes, write
// acknowledge, busy wait and trailing byte. Drives the byte shifter one byte
// at a time. Assumes DATA_BYTES >= 2 and POLL_LIMIT >= 2.
module sdx_ctrl
    import sdx_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int POLL_LIMIT = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       write_mode,
    input  logic [7:0] wr_data,
    input  logic       wr_valid,
    output logic       wr_ready,
    input  logic       fin,
    input  logic [7:0] rx_byte,
    output logic       go,
    output logic [7:0] tx_byte,
    output logic       cs_n,
    output logic [7:0] rd_data,
    output logic       rd_valid,
    output logic       done,
    output logic       error,
    output logic [2:0] err_status,
    output logic       busy
);
    localparam int CNTW = $clog2(DATA_BYTES);
    localparam int PLW  = $clog2(POLL_LIMIT);
    localparam logic [CNTW-1:0] CNT_LAST  = CNTW'(DATA_BYTES - 1);
    localparam logic [CNTW-1:0] CRC_LAST  = CNTW'(1);
    localparam logic [PLW-1:0]  POLL_LAST = PLW'(POLL_LIMIT - 1);

    xfer_st_e        state;
    logic            launched;
    logic [CNTW-1:0] cnt;
    logic [PLW-1:0]  poll;

    // Byte launch: one exchange outstanding at a time; payload writes wait for the producer.
    always_comb begin
        busy     = (state != ST_IDLE);
        wr_ready = (state == ST_WDATA) && !launched;
        go       = busy && !launched && ((state != ST_WDATA) || wr_valid);
        case (state)
            ST_WTOK:  tx_byte = TOK_START;
            ST_WDATA: tx_byte = wr_data;
            default:  tx_byte = FILL_BYTE;
        endcase
    end

    // Phase sequencer: advances on each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            launched   <= 1'b0;
            cnt        <= '0;
            poll       <= '0;
            cs_n       <= 1'b1;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            done       <= 1'b0;
            error      <= 1'b0;
            err_status <= '0;
        end else begin
            done     <= 1'b0;
            rd_valid <= 1'b0;
            if (go) begin
                launched <= 1'b1;
            end
            if (state == ST_IDLE) begin
                if (start) begin
                    cs_n       <= 1'b0;
                    error      <= 1'b0;
                    err_status <= '0;
                    cnt        <= '0;
                    poll       <= '0;
                    state      <= write_mode ? ST_WTOK : ST_RPOLL;
                end
            end else if (fin) begin
                launched <= 1'b0;
                case (state)
                    ST_RPOLL: begin
                        if (rx_byte == TOK_START) begin
                            cnt   <= '0;
                            state <= ST_RDATA;
                        end else if (poll == POLL_LAST) begin
                            error <= 1'b1;
                            cs_n  <= 1'b1;
                            state <= ST_TAIL;
                        end else begin
                            poll <= poll + PLW'(1);
                        end
                    end
                    ST_RDATA: begin
                        rd_valid <= 1'b1;
                        rd_data  <= rx_byte;
                        if (cnt == CNT_LAST) begin
                            cnt   <= '0;
                            state <= ST_RCRC;
                        end else begin
                            cnt <= cnt + CNTW'(1);
                        end
                    end
                    ST_RCRC: begin
                        if (cnt == CRC_LAST) begin
                            cs_n  <= 1'b1;
                            state <= ST_TAIL;
                        end else begin
                            cnt <= cnt + CNTW'(1);
                        end
                    end
                    ST_WTOK: begin
                        cnt   <= '0;
                        state <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt   <= '0;
                            state <= ST_WCRC;
                        end else begin
                            cnt <= cnt + CNTW'(1);
                        end
                    end
                    ST_WCRC: begin
                        if (cnt == CRC_LAST) begin
                            state <= ST_WRESP;
                        end else begin
                            cnt <= cnt + CNTW'(1);
                        end
                    end
                    ST_WRESP: begin
                        if ((rx_byte & ACK_MASK) == ACK_OK) begin
                            state <= ST_WBUSY;
                        end else begin
                            error      <= 1'b1;
                            err_status <= rx_byte[3:1];
                            cs_n       <= 1'b1;
                            state      <= ST_TAIL;
                        end
                    end
                    ST_WBUSY: begin
                        if (rx_byte != 8'h00) begin
                            cs_n  <= 1'b1;
                            state <= ST_TAIL;
                        end
                    end
                    ST_TAIL: begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdx_block_engine.sv
// Top of the SD single-block data-phase engine. Runs after the card has
// accepted a block command; owns the SPI pins for the data phase only.
// Assumes the caller issues start only while no transfer is in progress.
module sdx_block_engine #(
    parameter int DATA_BYTES = 512,
    parameter int POLL_LIMIT = 4096,
    parameter int CLK_DIV    = 2,
    parameter int ADDR_W     = 32,
    parameter int BLK_SHIFT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write_mode,
    input  logic [ADDR_W-1:0] block_num,
    input  logic              high_cap,
    output logic [ADDR_W-1:0] cmd_arg,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic              done,
    output logic              error,
    output logic [2:0]        err_status,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    logic       go;
    logic [7:0] tx_byte;
    logic       fin;
    logic [7:0] rx_byte;
    logic       sh_idle;
    logic       xfer_busy;

    sdx_addr_map #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_addr (
        .block_num (block_num),
        .high_cap  (high_cap),
        .cmd_arg   (cmd_arg)
    );

    sdx_ctrl #(.DATA_BYTES(DATA_BYTES), .POLL_LIMIT(POLL_LIMIT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .write_mode (write_mode),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .fin        (fin),
        .rx_byte    (rx_byte),
        .go         (go),
        .tx_byte    (tx_byte),
        .cs_n       (spi_cs_n),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .done       (done),
        .error      (error),
        .err_status (err_status),
        .busy       (xfer_busy)
    );

    sdx_spi_byte #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go && sh_idle),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .fin     (fin),
        .rx_byte (rx_byte),
        .idle    (sh_idle)
    );
endmodule

// File: rtl/sdx_block_engine_chk.sv
// Protocol checker for sdx_block_engine, attached through bind.
// Relates the chip select, SPI clock and stream handshakes to transfer activity.
module sdx_block_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       cs_n,
    input logic       sck,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       done,
    input logic       error,
    input logic [2:0] err_status
);
    // R1: no clocking toward the card while idle
    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R2: payload bytes appear only while the card is selected
    p_rd_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    // R5: write stream is only offered during a transfer
    p_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> busy);

    // R6: a clean outcome carries no status code
    p_ok_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (err_status == 3'd0));

    // R8: chip select released whenever the engine is idle
    p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R8: chip select rises only inside a transfer (entering the trailing byte)
    p_cs_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> busy);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind sdx_block_engine sdx_block_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (xfer_busy),
    .cs_n       (spi_cs_n),
    .sck        (spi_sck),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .done       (done),
    .error      (error),
    .err_status (err_status)
);

// File: tb/sim_sdx_block_engine.sv
`timescale 1ns/1ps
// Directed bench: a scripted SPI card model answers each byte; one task per scenario.
module sim_sdx_block_engine;
    localparam int DB = 16;
    localparam int PL = 20;
    localparam int CR = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        write_mode = 1'b0;
    logic [31:0] block_num = '0;
    logic        high_cap = 1'b0;
    logic [31:0] cmd_arg;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic        done;
    logic        error;
    logic [2:0]  err_status;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;
    logic        spi_cs_n;

    sdx_block_engine #(.DATA_BYTES(DB), .POLL_LIMIT(PL), .CLK_DIV(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
        .block_num(block_num), .high_cap(high_cap), .cmd_arg(cmd_arg),
        .rd_data(rd_data), .rd_valid(rd_valid), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .done(done), .error(error),
        .err_status(err_status), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    always #2.5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;

    // Card model state
    logic [7:0] cr [CR];
    logic [7:0] mo [CR];
    logic       csb [CR];
    logic [7:0] rdbuf [CR];
    int         nbytes = 0;
    int         bits = 0;
    int         nrd = 0;
    logic [7:0] in_sh = '0;
    logic [7:0] out_sh = 8'hFF;
    logic       got_err;
    logic [2:0] got_st;

    assign spi_miso = out_sh[7];

    // Card receive: capture MOSI on rising sck, record byte and chip select
    always @(posedge spi_sck) begin
        in_sh = {in_sh[6:0], spi_mosi};
        bits = bits + 1;
        if (bits == 8) begin
            bits = 0;
            if (nbytes < CR) begin
                mo[nbytes]  = in_sh;
                csb[nbytes] = spi_cs_n;
            end
            nbytes = nbytes + 1;
        end
    end

    // Card transmit: next bit on falling sck, next scripted byte at boundaries
    always @(negedge spi_sck) begin
        if (bits == 0) out_sh = (nbytes < CR) ? cr[nbytes] : 8'hFF;
        else           out_sh = {out_sh[6:0], 1'b1};
    end

    // Payload stream capture
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (nrd < CR) rdbuf[nrd] = rd_data;
            nrd = nrd + 1;
        end
    end

    function automatic logic [7:0] rpat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] wpat(int i);
        return 8'((i * 53 + 6) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic script_clear();
        for (int i = 0; i < CR; i++) cr[i] = 8'hFF;
    endtask

    task automatic feed();
        for (int k = 0; k < DB; k++) begin
            repeat (k % 3) @(negedge clk);
            wr_data  = wpat(k);
            wr_valid = 1'b1;
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
        end
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        got_err = error;
        got_st  = err_status;
    endtask

    task automatic run_xfer(input bit wr);
        nbytes = 0;
        bits   = 0;
        nrd    = 0;
        out_sh = cr[0];
        @(negedge clk);
        write_mode = wr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (wr) begin
            fork
                feed();
                wait_done();
            join
        end else begin
            wait_done();
        end
        @(negedge clk);
    endtask

    // Trailing byte with chip select high, all earlier bytes selected
    task automatic chk_frame(input int exp_n, input string req);
        bit sel_ok = 1'b1;
        chk(nbytes == exp_n, req, nbytes, exp_n);
        for (int i = 0; i + 1 < nbytes && i < CR; i++) if (csb[i] !== 1'b0) sel_ok = 1'b0;
        chk(sel_ok, "R8 cs low before tail", sel_ok, 1);
        if (nbytes > 0 && nbytes <= CR) begin
            chk(csb[nbytes-1] === 1'b1, "R8 cs high on tail", csb[nbytes-1], 1);
            chk(mo[nbytes-1] == 8'hFF, "R8 tail byte", mo[nbytes-1], 8'hFF);
        end
        chk(spi_cs_n === 1'b1, "R8 cs released after done", spi_cs_n, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
        chk(spi_sck === 1'b0, "R1 sck", spi_sck, 0);
        chk(spi_mosi === 1'b1, "R1 mosi", spi_mosi, 1);
        chk(done === 1'b0 && rd_valid === 1'b0 && wr_ready === 1'b0, "R1 strobes",
            {done, rd_valid, wr_ready}, 0);
        chk(error === 1'b0 && err_status === 3'd0, "R1 error state", {error, err_status}, 0);
    endtask

    task automatic t_addr();
        block_num = 32'd3; high_cap = 1'b0; #1;
        chk(cmd_arg == 32'd1536, "R9 byte-addressed", cmd_arg, 1536);
        block_num = 32'h0012_3456; high_cap = 1'b1; #1;
        chk(cmd_arg == 32'h0012_3456, "R9 block-addressed", cmd_arg, 32'h0012_3456);
        block_num = 32'h0040_0001; high_cap = 1'b0; #1;
        chk(cmd_arg == 32'h8000_0200, "R9 scaled wrap", cmd_arg, 32'h8000_0200);
    endtask

    task automatic t_read(input int nff);
        bit data_ok = 1'b1;
        bit mosi_ok = 1'b1;
        script_clear();
        cr[nff] = 8'hFE;
        for (int i = 0; i < DB; i++) cr[nff + 1 + i] = rpat(i);
        cr[nff + 1 + DB]     = 8'hA5;
        cr[nff + 2 + DB]     = 8'h5A;
        run_xfer(1'b0);
        chk(got_err == 1'b0, "R2 read outcome", got_err, 0);
        chk(nrd == DB, "R3 payload count excludes check bytes", nrd, DB);
        for (int i = 0; i < DB && i < nrd; i++) if (rdbuf[i] != rpat(i)) data_ok = 1'b0;
        chk(data_ok, "R2 payload order", data_ok, 1);
        for (int i = 0; i < nbytes && i < CR; i++) if (mo[i] != 8'hFF) mosi_ok = 1'b0;
        chk(mosi_ok, "R3 read sends only 0xFF", mosi_ok, 1);
        chk_frame(nff + DB + 4, "R2 R3 read byte count");
    endtask

    task automatic t_read_timeout();
        script_clear();
        run_xfer(1'b0);
        chk(got_err == 1'b1, "R4 timeout error", got_err, 1);
        chk(nrd == 0, "R4 no payload", nrd, 0);
        chk_frame(PL + 1, "R4 poll count");
    endtask

    task automatic t_write_ok();
        bit data_ok = 1'b1;
        script_clear();
        cr[DB + 3] = 8'hE5;
        cr[DB + 4] = 8'h00;
        cr[DB + 5] = 8'h00;
        cr[DB + 6] = 8'h01;
        run_xfer(1'b1);
        chk(got_err == 1'b0, "R6 masked ack accepted", got_err, 0);
        chk(got_st == 3'd0, "R6 status clear", got_st, 0);
        chk(mo[0] == 8'hFE, "R5 start token", mo[0], 8'hFE);
        for (int i = 0; i < DB; i++) if (mo[1 + i] != wpat(i)) data_ok = 1'b0;
        chk(data_ok, "R5 payload bytes", data_ok, 1);
        chk(mo[DB + 1] == 8'hFF && mo[DB + 2] == 8'hFF, "R5 filler check bytes",
            {mo[DB + 1], mo[DB + 2]}, 16'hFFFF);
        chk(mo[DB + 4] == 8'hFF && mo[DB + 5] == 8'hFF, "R7 fill during busy",
            {mo[DB + 4], mo[DB + 5]}, 16'hFFFF);
        chk_frame(DB + 8, "R7 busy wait length");
    endtask

    task automatic t_write_err(input logic [7:0] ack, input logic [2:0] st);
        script_clear();
        cr[DB + 3] = ack;
        cr[DB + 4] = 8'h00;
        run_xfer(1'b1);
        chk(got_err == 1'b1, "R6 rejected ack", got_err, 1);
        chk(got_st == st, "R6 status field", got_st, st);
        chk_frame(DB + 5, "R6 no busy wait after reject");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R8 watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        script_clear();
        t_reset();
        t_addr();
        t_read(3);
        t_read(0);
        t_read(PL - 1);
        t_read_timeout();
        t_write_ok();
        t_write_err(8'h0B, 3'b101);
        t_write_err(8'hED, 3'b110);
        t_read(1);
        summary();
        $finish;
    end
endmodule